// File: doc/BRIEF.md
# Graphics Colour Lookup and Video Mixer

This block turns a stream of graphics pixel codes into colour and lays that colour over live video. Each code is 2, 4 or 8 bits wide. It selects one entry of a 256-entry colour table. Every table entry holds luma (Y), two chroma values (U, V) and a 6-bit transparency (T).

For short codes, an optional remap stage sits in front of the colour table. It lets a region coded with few bits use any chosen subset of a larger table. Three remap tables are available:
- 16 codes onto 256 entries.
- 4 codes onto 256 entries.
- 4 codes onto the first 16 entries.

The looked-up colour is blended with the video pixel that arrives alongside the code. The blend has 64 levels set by T. When no graphics code is valid, the video passes through untouched.

A controlling processor loads the colour table and the three remap tables through a simple write port. Writes are accepted only while no graphics pixel is being presented. This means a table cannot change partway through a graphics region. The pixel path is a fixed three-cycle pipeline, and the video is delayed with it so that both stay aligned.

Top module: `osd_clut_mixer`

## Requirements
- R1: While `rst_n` is low, `mix_yuv` reads zero.
- R2: A video pixel presented with `pix_valid` low appears unchanged on `mix_yuv`.
- R3: With `pix_bpp` = 2'b10 (8 bits per pixel; 2'b11 behaves the same), all 8 bits of `pix_code` index the colour table directly, and `map_en` has no effect.
- R4: With `map_en` low, the code bits in use are zero-extended to 8 bits and index the colour table directly. For `pix_bpp` = 2'b00 (2 bits per pixel) these are `pix_code[1:0]`. For `pix_bpp` = 2'b01 (4 bits per pixel) these are `pix_code[3:0]`. Higher code bits are ignored.
- R5: With `pix_bpp` = 2'b01 and `map_en` high, `pix_code[3:0]` selects one of 16 remap entries, and that 8-bit entry is the table index.
- R6: With `pix_bpp` = 2'b00, `map_en` high and `map_narrow` low, `pix_code[1:0]` selects one of 4 remap entries of 8 bits, and that entry is the table index.
- R7: With `pix_bpp` = 2'b00, `map_en` high and `map_narrow` high, `pix_code[1:0]` selects one of 4 remap entries of 4 bits. The entry, zero-extended, is the table index, so only the first 16 table entries are reachable.
- R8: For a valid pixel, each output component is (G·T + V·(63−T) + 31) / 63 with integer division. Here G is the graphics component, V the video component, and T the entry's transparency. The result always lies between G and V.
- R9: T = 0 gives the video component exactly, and T = 63 gives the graphics component exactly.
- R10: Inputs presented before clock edge k reach `mix_yuv` at edge k+3.
- R11: A table write is ignored if `pix_valid` is high in its cycle. `cpu_sel` selects the target:
  - 2'b00: colour table, data in `cpu_wdata` [29:22] Y, [21:14] U, [13:6] V, [5:0] T.
  - 2'b01: 16-entry remap table, data in `cpu_wdata[7:0]`.
  - 2'b10: 4-entry wide remap table, data in `cpu_wdata[7:0]`.
  - 2'b11: 4-entry narrow remap table, data in `cpu_wdata[3:0]`.
  
  The entry is selected by `cpu_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_we | input | 1 | Table write strobe |
| cpu_sel | input | 2 | Target table of the write |
| cpu_addr | input | 8 | Entry written |
| cpu_wdata | input | 30 | Write data (Y, U, V, T packed high to low) |
| pix_valid | input | 1 | Graphics code valid for this pixel |
| pix_code | input | 8 | Graphics pixel code |
| pix_bpp | input | 2 | Code width: 00 = 2, 01 = 4, 1x = 8 bits |
| map_en | input | 1 | Route short codes through a remap table |
| map_narrow | input | 1 | For 2-bit codes, use the 4-to-16 remap table |
| vid_yuv | input | 24 | Video pixel, Y[23:16] U[15:8] V[7:0] |
| mix_yuv | output | 24 | Mixed pixel, same packing, three cycles later |

## Verification
The bench builds the block with its default parameters: 8-bit components, 6-bit transparency and an 8-bit table address. With these values every one of the 256 colour entries and all 64 blend levels can be reached from the pins. The bench fills the whole table and all three remap tables, then streams randomly chosen code widths and remap settings against a reference blend. Directed pixels cover the two extreme transparency values, a rounding case, the exact three-cycle output step, and writes attempted while a graphics pixel is being presented.

// File: rtl/gcm_pkg.sv
package gcm_pkg;

  // Code width of a graphics pixel
  typedef enum logic [1:0] {
    BPP_2 = 2'b00,
    BPP_4 = 2'b01,
    BPP_8 = 2'b10
  } bpp_e;

  // Target of a processor table write
  typedef enum logic [1:0] {
    TBL_CLUT    = 2'b00,
    TBL_WIDE16  = 2'b01,
    TBL_WIDE4   = 2'b10,
    TBL_NARROW4 = 2'b11
  } tbl_e;

endpackage

// File: rtl/gcm_code_map.sv
module gcm_code_map
  import gcm_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int NIDX_W = 4,
  parameter int WIDE_N = 16,
  parameter int SHORT_N = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tbl_we,
  input  logic [1:0]       tbl_sel,
  input  logic [IDX_W-1:0] tbl_addr,
  input  logic [IDX_W-1:0] tbl_data,
  input  logic [IDX_W-1:0] code,
  input  logic [1:0]       bpp,
  input  logic             map_en,
  input  logic             map_narrow,
  output logic [IDX_W-1:0] idx
);

  localparam int WA = $clog2(WIDE_N);
  localparam int SA = $clog2(SHORT_N);

  logic [IDX_W-1:0]  wide16_q [WIDE_N];
  logic [IDX_W-1:0]  wide16_d [WIDE_N];
  logic [IDX_W-1:0]  wide4_q  [SHORT_N];
  logic [IDX_W-1:0]  wide4_d  [SHORT_N];
  logic [NIDX_W-1:0] narrow_q [SHORT_N];
  logic [NIDX_W-1:0] narrow_d [SHORT_N];

  // next-state of the remap tables
  always_comb begin
    wide16_d = wide16_q;
    wide4_d  = wide4_q;
    narrow_d = narrow_q;
    if (tbl_we) begin
      case (tbl_sel)
        TBL_WIDE16:  wide16_d[tbl_addr[WA-1:0]] = tbl_data;
        TBL_WIDE4:   wide4_d[tbl_addr[SA-1:0]]  = tbl_data;
        TBL_NARROW4: narrow_d[tbl_addr[SA-1:0]] = tbl_data[NIDX_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wide16_q <= '{default: '0};
      wide4_q  <= '{default: '0};
      narrow_q <= '{default: '0};
    end else begin
      wide16_q <= wide16_d;
      wide4_q  <= wide4_d;
      narrow_q <= narrow_d;
    end
  end

  // code to colour-table index
  always_comb begin
    case (bpp)
      BPP_2: begin
        if (!map_en)         idx = IDX_W'(code[SA-1:0]);
        else if (map_narrow) idx = IDX_W'(narrow_q[code[SA-1:0]]);
        else                 idx = wide4_q[code[SA-1:0]];
      end
      BPP_4: begin
        if (!map_en) idx = IDX_W'(code[WA-1:0]);
        else         idx = wide16_q[code[WA-1:0]];
      end
      default: idx = code;
    endcase
  end

endmodule

// File: rtl/gcm_clut_ram.sv
module gcm_clut_ram #(
  parameter int AW = 8,
  parameter int DW = 30
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // storage array, no reset
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  // registered read port
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_data <= '0;
    else        rd_data <= mem[rd_addr];
  end

endmodule

// File: rtl/gcm_blend.sv
module gcm_blend #(
  parameter int CW = 8,
  parameter int TW = 6,
  parameter int NC = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [NC*CW-1:0] gfx,
  input  logic [TW-1:0]    alpha,
  input  logic [NC*CW-1:0] vid,
  output logic [NC*CW-1:0] mix
);

  localparam int TMAX = (1 << TW) - 1;
  localparam int SW   = CW + TW + 1;

  logic [NC*CW-1:0] mix_d;
  logic [TW-1:0]    beta;

  assign beta = TW'(TMAX) - alpha;

  generate
    for (genvar c = 0; c < NC; c++) begin : g_comp
      logic [SW-1:0] acc;
      logic [SW-1:0] quo;
      always_comb begin
        acc = SW'(gfx[c*CW +: CW]) * SW'(alpha)
            + SW'(vid[c*CW +: CW]) * SW'(beta)
            + SW'(TMAX / 2);
        quo = acc / SW'(TMAX);
      end
      assign mix_d[c*CW +: CW] = in_valid ? quo[CW-1:0] : vid[c*CW +: CW];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mix <= '0;
    else        mix <= mix_d;
  end

endmodule

// File: rtl/osd_clut_mixer.sv
module osd_clut_mixer
  import gcm_pkg::*;
#(
  parameter int CW = 8,
  parameter int TW = 6,
  parameter int AW = 8,
  parameter int NARROW_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_we,
  input  logic [1:0]        cpu_sel,
  input  logic [AW-1:0]     cpu_addr,
  input  logic [3*CW+TW-1:0] cpu_wdata,
  input  logic              pix_valid,
  input  logic [AW-1:0]     pix_code,
  input  logic [1:0]        pix_bpp,
  input  logic              map_en,
  input  logic              map_narrow,
  input  logic [3*CW-1:0]   vid_yuv,
  output logic [3*CW-1:0]   mix_yuv
);

  localparam int VW = 3 * CW;
  localparam int DW = VW + TW;

  // reset: asynchronous assert, synchronous release
  logic rst_meta, srst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      srst_n   <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      srst_n   <= rst_meta;
    end
  end

  // table writes only between graphics pixels
  logic wr_ok, clut_we, map_we;
  assign wr_ok   = cpu_we && !pix_valid;
  assign clut_we = wr_ok && (cpu_sel == TBL_CLUT);
  assign map_we  = wr_ok && (cpu_sel != TBL_CLUT);

  // stage 0: code to index
  logic [AW-1:0] idx_c;
  gcm_code_map #(
    .IDX_W (AW),
    .NIDX_W(NARROW_W),
    .WIDE_N(16),
    .SHORT_N(4)
  ) u_map (
    .clk       (clk),
    .rst_n     (srst_n),
    .tbl_we    (map_we),
    .tbl_sel   (cpu_sel),
    .tbl_addr  (cpu_addr),
    .tbl_data  (cpu_wdata[AW-1:0]),
    .code      (pix_code),
    .bpp       (pix_bpp),
    .map_en    (map_en),
    .map_narrow(map_narrow),
    .idx       (idx_c)
  );

  // stage 1 registers
  logic          s1_valid, s1_valid_d;
  logic [VW-1:0] s1_vid, s1_vid_d;
  logic [AW-1:0] s1_idx, s1_idx_d;

  always_comb begin
    s1_valid_d = pix_valid;
    s1_vid_d   = vid_yuv;
    s1_idx_d   = idx_c;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      s1_valid <= 1'b0;
      s1_vid   <= '0;
      s1_idx   <= '0;
    end else begin
      s1_valid <= s1_valid_d;
      s1_vid   <= s1_vid_d;
      s1_idx   <= s1_idx_d;
    end
  end

  // stage 2: colour lookup
  logic [DW-1:0] s2_gfx;
  gcm_clut_ram #(
    .AW(AW),
    .DW(DW)
  ) u_clut (
    .clk    (clk),
    .rst_n  (srst_n),
    .wr_en  (clut_we),
    .wr_addr(cpu_addr),
    .wr_data(cpu_wdata),
    .rd_addr(s1_idx),
    .rd_data(s2_gfx)
  );

  logic          s2_valid, s2_valid_d;
  logic [VW-1:0] s2_vid, s2_vid_d;

  always_comb begin
    s2_valid_d = s1_valid;
    s2_vid_d   = s1_vid;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      s2_valid <= 1'b0;
      s2_vid   <= '0;
    end else begin
      s2_valid <= s2_valid_d;
      s2_vid   <= s2_vid_d;
    end
  end

  // stage 3: blend
  gcm_blend #(
    .CW(CW),
    .TW(TW),
    .NC(3)
  ) u_blend (
    .clk     (clk),
    .rst_n   (srst_n),
    .in_valid(s2_valid),
    .gfx     (s2_gfx[DW-1:TW]),
    .alpha   (s2_gfx[TW-1:0]),
    .vid     (s2_vid),
    .mix     (mix_yuv)
  );

endmodule

// File: rtl/gcm_checker.sv
module gcm_checker #(
  parameter int CW = 8,
  parameter int TW = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pix_valid,
  input logic [3*CW-1:0]   vid_yuv,
  input logic [3*CW-1:0]   mix_yuv,
  input logic              s2_valid,
  input logic [3*CW-1:0]   s2_vid,
  input logic [3*CW+TW-1:0] s2_gfx
);

  localparam int TMAX = (1 << TW) - 1;

  logic [2:0] up_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             up_cnt <= '0;
    else if (up_cnt != 3'd7) up_cnt <= up_cnt + 3'd1;
  end

  function automatic logic between(input logic [CW-1:0] a, input logic [CW-1:0] b,
                                   input logic [CW-1:0] x);
    return (a <= b) ? (x >= a && x <= b) : (x >= b && x <= a);
  endfunction

  logic [3*CW-1:0] s2_col;
  logic [TW-1:0]   s2_t;
  assign s2_col = s2_gfx[3*CW+TW-1:TW];
  assign s2_t   = s2_gfx[TW-1:0];

  AST_PASS_VIDEO: assert property (@(posedge clk) disable iff (!rst_n)
    (up_cnt >= 3'd4 && $past(!pix_valid, 3)) |-> mix_yuv == $past(vid_yuv, 3)); // R2

  AST_CLEAR_KEEPS_VIDEO: assert property (@(posedge clk) disable iff (!rst_n)
    (s2_valid && s2_t == '0) |=> mix_yuv == $past(s2_vid)); // R9

  AST_OPAQUE_SHOWS_GFX: assert property (@(posedge clk) disable iff (!rst_n)
    (s2_valid && s2_t == TW'(TMAX)) |=> mix_yuv == $past(s2_col)); // R9

  AST_MIX_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    s2_valid |=> (between($past(s2_col[3*CW-1:2*CW]), $past(s2_vid[3*CW-1:2*CW]), mix_yuv[3*CW-1:2*CW])
               && between($past(s2_col[2*CW-1:CW]), $past(s2_vid[2*CW-1:CW]), mix_yuv[2*CW-1:CW])
               && between($past(s2_col[CW-1:0]), $past(s2_vid[CW-1:0]), mix_yuv[CW-1:0]))); // R8

endmodule

bind osd_clut_mixer gcm_checker #(.CW(CW), .TW(TW)) u_gcm_checker (
  .clk      (clk),
  .rst_n    (srst_n),
  .pix_valid(pix_valid),
  .vid_yuv  (vid_yuv),
  .mix_yuv  (mix_yuv),
  .s2_valid (s2_valid),
  .s2_vid   (s2_vid),
  .s2_gfx   (s2_gfx)
);

// File: tb/test_osd_clut_mixer.sv
module test_osd_clut_mixer;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cpu_we;
  logic [1:0]  cpu_sel;
  logic [7:0]  cpu_addr;
  logic [29:0] cpu_wdata;
  logic        pix_valid;
  logic [7:0]  pix_code;
  logic [1:0]  pix_bpp;
  logic        map_en;
  logic        map_narrow;
  logic [23:0] vid_yuv;
  logic [23:0] mix_yuv;

  osd_clut_mixer i_osd_clut_mixer (
    .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_sel(cpu_sel),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .pix_valid(pix_valid),
    .pix_code(pix_code), .pix_bpp(pix_bpp), .map_en(map_en),
    .map_narrow(map_narrow), .vid_yuv(vid_yuv), .mix_yuv(mix_yuv)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit chk_on = 1'b0;

  logic [29:0] clut_m [256];
  logic [7:0]  w16_m [16];
  logic [7:0]  w4_m [4];
  logic [3:0]  n4_m [4];

  logic [23:0] exp_q [4];
  string       tag_q [4];
  bit          pend_q [4];

  function automatic logic [7:0] blend1(input logic [7:0] g, input logic [7:0] v,
                                       input logic [5:0] t);
    int s;
    s = int'(g) * int'(t) + int'(v) * (63 - int'(t)) + 31;
    return 8'(s / 63);
  endfunction

  function automatic logic [7:0] ref_idx(input logic [7:0] c, input logic [1:0] b,
                                        input logic me, input logic mn);
    case (b)
      2'b00:   return me ? (mn ? {4'b0, n4_m[c[1:0]]} : w4_m[c[1:0]]) : {6'b0, c[1:0]};
      2'b01:   return me ? w16_m[c[3:0]] : {4'b0, c[3:0]};
      default: return c;
    endcase
  endfunction

  function automatic logic [23:0] ref_mix(input logic v, input logic [7:0] c,
                                         input logic [1:0] b, input logic me,
                                         input logic mn, input logic [23:0] vid);
    logic [29:0] e;
    if (!v) return vid;
    e = clut_m[ref_idx(c, b, me, mn)];
    return {blend1(e[29:22], vid[23:16], e[5:0]),
            blend1(e[21:14], vid[15:8],  e[5:0]),
            blend1(e[13:6],  vid[7:0],   e[5:0])};
  endfunction

  task automatic check(input string tag, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // one pixel cycle: check output of three cycles ago, then drive new inputs
  task automatic step(input logic v, input logic [7:0] c, input logic [1:0] b,
                      input logic me, input logic mn, input logic [23:0] vid,
                      input logic we, input logic [1:0] sel, input logic [7:0] a,
                      input logic [29:0] wd, input string tag);
    int slot;
    @(negedge clk);
    slot = (cyc + 1) % 4;
    if (chk_on && pend_q[slot]) check(tag_q[slot], mix_yuv, exp_q[slot]);
    pix_valid = v; pix_code = c; pix_bpp = b; map_en = me; map_narrow = mn;
    vid_yuv = vid; cpu_we = we; cpu_sel = sel; cpu_addr = a; cpu_wdata = wd;
    exp_q[cyc % 4]  = ref_mix(v, c, b, me, mn, vid);
    tag_q[cyc % 4]  = tag;
    pend_q[cyc % 4] = chk_on;
    if (we && !v) begin
      case (sel)
        2'b00: clut_m[a]     = wd;
        2'b01: w16_m[a[3:0]] = wd[7:0];
        2'b10: w4_m[a[1:0]]  = wd[7:0];
        default: n4_m[a[1:0]] = wd[3:0];
      endcase
    end
    cyc++;
  endtask

  task automatic idle(input string tag);
    step(1'b0, 8'(($urandom)), 2'b10, 1'b0, 1'b0, 24'($urandom), 1'b0, 2'b00, 8'h00, 30'h0, tag);
  endtask

  task automatic summary;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired, actual running expected finished");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd20250));
    for (int i = 0; i < 4; i++) pend_q[i] = 1'b0;
    rst_n = 1'b0;
    pix_valid = 1'b0; pix_code = '0; pix_bpp = '0; map_en = 1'b0; map_narrow = 1'b0;
    vid_yuv = 24'hA5C3E1; cpu_we = 1'b0; cpu_sel = '0; cpu_addr = '0; cpu_wdata = '0;

    // R1: output held at zero in reset
    repeat (3) @(negedge clk);
    check("R1", mix_yuv, 24'h0);
    vid_yuv = 24'h123456; pix_valid = 1'b1;
    repeat (2) @(negedge clk);
    check("R1", mix_yuv, 24'h0);
    pix_valid = 1'b0;
    rst_n = 1'b1;
    repeat (5) idle("R2");
    chk_on = 1'b1;

    // fill colour table with valid low (R2 on the video path meanwhile)
    for (int i = 0; i < 256; i++)
      step(1'b0, 8'h00, 2'b10, 1'b0, 1'b0, 24'($urandom), 1'b1, 2'b00, 8'(i),
           30'($urandom), "R2");
    // remap tables
    for (int i = 0; i < 16; i++)
      step(1'b0, 8'h00, 2'b10, 1'b0, 1'b0, 24'($urandom), 1'b1, 2'b01, 8'(i), 30'($urandom), "R2");
    for (int i = 0; i < 4; i++)
      step(1'b0, 8'h00, 2'b10, 1'b0, 1'b0, 24'($urandom), 1'b1, 2'b10, 8'(i), 30'($urandom), "R2");
    for (int i = 0; i < 4; i++)
      step(1'b0, 8'h00, 2'b10, 1'b0, 1'b0, 24'($urandom), 1'b1, 2'b11, 8'(i), 30'($urandom), "R2");

    // directed transparency extremes and rounding
    step(1'b0, 8'h00, 2'b10, 1'b0, 1'b0, 24'h0, 1'b1, 2'b00, 8'd20, {8'd200, 8'd17, 8'd90, 6'd0}, "R2");
    step(1'b0, 8'h00, 2'b10, 1'b0, 1'b0, 24'h0, 1'b1, 2'b00, 8'd21, {8'd200, 8'd17, 8'd90, 6'd63}, "R2");
    step(1'b0, 8'h00, 2'b10, 1'b0, 1'b0, 24'h0, 1'b1, 2'b00, 8'd22, {8'd255, 8'd0, 8'd200, 6'd1}, "R2");
    step(1'b1, 8'd20, 2'b10, 1'b0, 1'b0, 24'h3C7F0A, 1'b0, 2'b00, 8'h0, 30'h0, "R9");
    step(1'b1, 8'd21, 2'b10, 1'b0, 1'b0, 24'h3C7F0A, 1'b0, 2'b00, 8'h0, 30'h0, "R9");
    step(1'b1, 8'd22, 2'b10, 1'b0, 1'b0, 24'h00FFC8, 1'b0, 2'b00, 8'h0, 30'h0, "R8");
    step(1'b1, 8'd22, 2'b10, 1'b1, 1'b0, 24'h80FF00, 1'b0, 2'b00, 8'h0, 30'h0, "R3");

    // random mix of code widths and remap settings
    for (int n = 0; n < 500; n++) begin
      int mode;
      logic v;
      mode = int'($urandom_range(0, 5));
      v = ($urandom_range(0, 9) < 8);
      if (!v && $urandom_range(0, 3) == 0) begin
        step(1'b0, 8'h0, 2'b10, 1'b0, 1'b0, 24'($urandom), 1'b1, 2'b00,
             8'($urandom), 30'($urandom), "R2");
      end else begin
        case (mode)
          0: step(v, 8'($urandom), 2'b10 | 2'($urandom_range(0, 1)), 1'($urandom), 1'($urandom),
                  24'($urandom), 1'b0, 2'b00, 8'h0, 30'h0, v ? "R3" : "R2");
          1: step(v, 8'($urandom), 2'b00, 1'b0, 1'($urandom), 24'($urandom), 1'b0, 2'b00, 8'h0, 30'h0,
                  v ? "R4" : "R2");
          2: step(v, 8'($urandom), 2'b01, 1'b0, 1'($urandom), 24'($urandom), 1'b0, 2'b00, 8'h0, 30'h0,
                  v ? "R4" : "R2");
          3: step(v, 8'($urandom), 2'b01, 1'b1, 1'($urandom), 24'($urandom), 1'b0, 2'b00, 8'h0, 30'h0,
                  v ? "R5" : "R2");
          4: step(v, 8'($urandom), 2'b00, 1'b1, 1'b0, 24'($urandom), 1'b0, 2'b00, 8'h0, 30'h0,
                  v ? "R6" : "R2");
          default: step(v, 8'($urandom), 2'b00, 1'b1, 1'b1, 24'($urandom), 1'b0, 2'b00, 8'h0, 30'h0,
                  v ? "R7" : "R2");
        endcase
      end
    end

    // R10: a single step in the video lands exactly three edges later
    for (int i = 0; i < 4; i++)
      step(1'b0, 8'h0, 2'b10, 1'b0, 1'b0, 24'h111111, 1'b0, 2'b00, 8'h0, 30'h0, "R10");
    for (int i = 0; i < 4; i++)
      step(1'b0, 8'h0, 2'b10, 1'b0, 1'b0, 24'hEEEEEE, 1'b0, 2'b00, 8'h0, 30'h0, "R10");

    // R11: writes attempted while a graphics pixel is presented are dropped
    step(1'b1, 8'd5, 2'b10, 1'b0, 1'b0, 24'h204060, 1'b1, 2'b00, 8'd5,
         {8'd1, 8'd2, 8'd3, 6'd63}, "R11");
    step(1'b1, 8'd5, 2'b10, 1'b0, 1'b0, 24'h204060, 1'b1, 2'b01, 8'd3, 30'h000AB, "R11");
    step(1'b1, 8'd5, 2'b10, 1'b0, 1'b0, 24'h204060, 1'b1, 2'b11, 8'd2, 30'h0000F, "R11");
    step(1'b1, 8'd5, 2'b10, 1'b0, 1'b0, 24'h907050, 1'b0, 2'b00, 8'h0, 30'h0, "R11");
    step(1'b1, 8'd3, 2'b01, 1'b1, 1'b0, 24'h907050, 1'b0, 2'b00, 8'h0, 30'h0, "R11");
    step(1'b1, 8'd2, 2'b00, 1'b1, 1'b1, 24'h907050, 1'b0, 2'b00, 8'h0, 30'h0, "R11");

    repeat (4) idle("R2");
    summary();
    $finish;
  end

endmodule